// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Error Flags

This block is the receive half of an asynchronous serial port. It watches a serial line that idles high and treats a falling edge as a possible start bit. It accepts the start bit only if the line is still low halfway through the bit. Every later bit is sampled once, at its middle, on a 16x oversampling enable that comes from outside. Data bits arrive least significant first and are placed from bit 0 upward. After them come an optional parity bit and one or two stop bits.

When the last expected stop bit has been sampled, the character moves into a holding register that the host reads, and the data-ready output rises. The shift logic can then take the next character while the host still holds the previous one. Parity, framing, overrun and break conditions are kept as sticky flags. A buffer-read strobe clears data-ready. A status-read strobe clears the four error flags. Word length, parity mode and stop-bit selection come from the same control word that drives the transmitter, so some codes produce a parity or stop pattern that the receiver treats differently.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, `data_rdy`, `err_par`, `err_frm`, `err_ovr` and `brk_det` are 0 and `rx_data` is 0.
- R2: The first data bit after the start bit is stored in `rx_data[0]`. When the character completes, `rx_data` holds it and `data_rdy` is 1.
- R3: `cfg_wlen` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. A shorter character is right-justified in `rx_data`, and the unused upper bits read 0.
- R4: A parity bit follows the data unless `cfg_par` is 11x. Codes 000 and 011 check for even parity over the data and parity bits. Codes 001 and 010 check for odd parity. Codes 100, 101 and 11x never set `err_par`.
- R5: With `cfg_stop2`=1 and a word length of 6, 7 or 8, two stop bits are expected, and the character completes at the second one. With a 5-bit word, only one stop bit is expected whatever `cfg_stop2` is.
- R6: `err_frm` is set when any expected stop-bit sample is low.
- R7: `brk_det` is set, together with `err_frm`, when every data bit, the parity bit if present, and the first stop bit all sample low.
- R8: A low pulse on the line that has ended before the middle of the start bit is discarded, and no character is received.
- R9: If a character completes while `data_rdy` is still 1, `err_ovr` is set. `rx_data` keeps the unread character, and the new character's data and error results are discarded.
- R10: A one-cycle `rd_buf` pulse clears `data_rdy` and leaves `rx_data` unchanged.
- R11: A one-cycle `rd_stat` pulse clears `err_par`, `err_frm`, `err_ovr` and `brk_det` and does not change `data_rdy`. Until then these flags stay set.
- R12: While `rx_en` is 0, no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | 16x oversampling enable |
| rx_en | input | 1 | Receiver enable |
| serial_in | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Word-length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop2 | input | 1 | Stop-bit select |
| rd_buf | input | 1 | Buffer read strobe |
| rd_stat | input | 1 | Status read strobe |
| rx_data | output | 8 | Received character |
| data_rdy | output | 1 | Data-ready output and flag |
| err_par | output | 1 | Parity error flag |
| err_frm | output | 1 | Framing error flag |
| err_ovr | output | 1 | Overrun flag |
| brk_det | output | 1 | Received-break flag |

## Verification
The hardest cases to reach are the ones where the stop-bit setting changes only when a character completes, not what it contains: 5-bit words with the stop select set, compared with 8-bit words. The stimulus stops driving right after the first stop bit and samples `data_rdy` in the gap before a second stop bit would be sampled. The break case needs an all-zero character with a low stop bit, followed by the line returning high. The check confirms that the long low is not read as a new start bit. Overrun is reached by sending two characters back to back with no read in between.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_DRAIN
  } rx_state_e;

  function automatic int wlen_bits(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  function automatic logic par_present(input logic [2:0] code);
    return !(code[2] && code[1]);
  endfunction

  function automatic logic par_checked(input logic [2:0] code);
    return !code[2];
  endfunction

  // 1 when the receiver expects an odd count of ones over data and parity
  function automatic logic par_odd(input logic [2:0] code);
    return code[1] ^ code[0];
  endfunction

  function automatic logic two_stops(input logic stop_sel, input logic [1:0] wlen);
    return stop_sel && (wlen != 2'b00);
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= din;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rxu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              line,
  input  logic [1:0]        cfg_wlen,
  input  logic [2:0]        cfg_par,
  input  logic              cfg_stop2,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              acc_q, any1_q, ferr_q, brk_q, second_q;

  logic [BW-1:0] nbits;
  logic          samp;       // mid-bit sampling event
  logic          start_ok;   // start bit confirmed at mid-bit
  logic          last_stop;  // sampling the final expected stop bit

  assign nbits     = BW'(wlen_bits(cfg_wlen));
  assign samp      = tick && (cnt_q == LAST);
  assign start_ok  = (state_q == RX_START) && tick && (cnt_q == MID) && !line;
  assign last_stop = (state_q == RX_STOP) && samp &&
                     (second_q || !two_stops(cfg_stop2, cfg_wlen));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      bidx_q   <= '0;
      shreg_q  <= '0;
      acc_q    <= 1'b0;
      any1_q   <= 1'b0;
      ferr_q   <= 1'b0;
      brk_q    <= 1'b0;
      second_q <= 1'b0;
      done_o   <= 1'b0;
      data_o   <= '0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
      brk_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          RX_IDLE: if (tick && !line) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
          RX_START: if (tick) begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (start_ok) begin
                state_q  <= RX_DATA;
                bidx_q   <= '0;
                shreg_q  <= '0;
                acc_q    <= 1'b0;
                any1_q   <= 1'b0;
                ferr_q   <= 1'b0;
                brk_q    <= 1'b0;
                second_q <= 1'b0;
              end else begin
                state_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (samp) begin
              shreg_q <= shreg_q | (DATA_W'(line) << bidx_q);
              acc_q   <= acc_q ^ line;
              any1_q  <= any1_q | line;
              bidx_q  <= bidx_q + 1'b1;
              if (bidx_q == nbits - 1'b1)
                state_q <= par_present(cfg_par) ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (samp) begin
              acc_q   <= acc_q ^ line;
              any1_q  <= any1_q | line;
              state_q <= RX_STOP;
            end
          end
          RX_STOP: if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (samp) begin
              ferr_q <= ferr_q | !line;
              if (!second_q) brk_q <= !any1_q && !line;
              if (last_stop) begin
                done_o  <= 1'b1;
                data_o  <= shreg_q;
                perr_o  <= par_checked(cfg_par) && (acc_q ^ par_odd(cfg_par));
                ferr_o  <= ferr_q | !line;
                brk_o   <= second_q ? brk_q : (!any1_q && !line);
                state_q <= line ? RX_IDLE : RX_DRAIN;
              end else begin
                second_q <= 1'b1;
              end
            end
          end
          RX_DRAIN: if (line) state_q <= RX_IDLE;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R12
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state_q == RX_IDLE));
  // R7
  brk_has_ferr_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && brk_o |-> ferr_o);
  // R2
  done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(state_q == RX_STOP));
  // R8
  start_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_START) && tick && (cnt_q == MID) && line |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              brk_i,
  input  logic              rd_buf,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] rbuf_o,
  output logic              drdy_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              oe_o,
  output logic              bk_o
);
  logic load, overrun;
  assign load    = done_i && !drdy_o;
  assign overrun = done_i && drdy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbuf_o <= '0;
      drdy_o <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      oe_o   <= 1'b0;
      bk_o   <= 1'b0;
    end else begin
      if (load) rbuf_o <= data_i;
      if (load) drdy_o <= 1'b1;
      else if (rd_buf) drdy_o <= 1'b0;
      pe_o <= (load && perr_i) || (pe_o && !rd_stat);
      fe_o <= (load && ferr_i) || (fe_o && !rd_stat);
      bk_o <= (load && brk_i)  || (bk_o && !rd_stat);
      oe_o <= overrun || (oe_o && !rd_stat);
    end
  end

  // R2
  rdy_from_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy_o) |-> $past(done_i));
  // R9
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> $past(done_i && drdy_o));
  // R9
  held_buffer_chk: assert property (@(posedge clk) disable iff (rst)
    drdy_o |=> $stable(rbuf_o));
  // R11
  stat_keeps_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stat && !rd_buf && !done_i |=> $stable(drdy_o));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              serial_in,
  input  logic [1:0]        cfg_wlen,
  input  logic [2:0]        cfg_par,
  input  logic              cfg_stop2,
  input  logic              rd_buf,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_rdy,
  output logic              err_par,
  output logic              err_frm,
  output logic              err_ovr,
  output logic              brk_det
);
  logic              line_s;
  logic              chr_done;
  logic [DATA_W-1:0] chr_data;
  logic              chr_perr, chr_ferr, chr_brk;

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(serial_in), .dout(line_s)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) frame_i (
    .clk(clk), .rst(rst), .tick(os_tick), .en(rx_en), .line(line_s),
    .cfg_wlen(cfg_wlen), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .done_o(chr_done), .data_o(chr_data), .perr_o(chr_perr),
    .ferr_o(chr_ferr), .brk_o(chr_brk)
  );

  rx_holding #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .done_i(chr_done), .data_i(chr_data),
    .perr_i(chr_perr), .ferr_i(chr_ferr), .brk_i(chr_brk),
    .rd_buf(rd_buf), .rd_stat(rd_stat), .rbuf_o(rx_data),
    .drdy_o(data_rdy), .pe_o(err_par), .fe_o(err_frm),
    .oe_o(err_ovr), .bk_o(brk_det)
  );
endmodule

// File: tb/uart_rx_dbuf_tb_top.sv
module uart_rx_dbuf_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b1;
  logic rx_en = 1'b1;
  logic serial_in = 1'b1;
  logic [1:0] cfg_wlen = 2'b11;
  logic [2:0] cfg_par = 3'b110;
  logic cfg_stop2 = 1'b0;
  logic rd_buf = 1'b0;
  logic rd_stat = 1'b0;
  logic [7:0] rx_data;
  logic data_rdy, err_par, err_frm, err_ovr, brk_det;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [7:0] m_data = 8'h00;
  bit m_rdy = 0, m_pe = 0, m_fe = 0, m_oe = 0, m_bk = 0;

  always #5 clk = ~clk;

  uart_rx_dbuf dut_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_en(rx_en),
    .serial_in(serial_in), .cfg_wlen(cfg_wlen), .cfg_par(cfg_par),
    .cfg_stop2(cfg_stop2), .rd_buf(rd_buf), .rd_stat(rd_stat),
    .rx_data(rx_data), .data_rdy(data_rdy), .err_par(err_par),
    .err_frm(err_frm), .err_ovr(err_ovr), .brk_det(brk_det)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    cmp(req, "rx_data", int'(rx_data), int'(m_data));
    cmp(req, "data_rdy", int'(data_rdy), int'(m_rdy));
    cmp(req, "err_par", int'(err_par), int'(m_pe));
    cmp(req, "err_frm", int'(err_frm), int'(m_fe));
    cmp(req, "err_ovr", int'(err_ovr), int'(m_oe));
    cmp(req, "brk_det", int'(brk_det), int'(m_bk));
  endtask

  task automatic hold_bit(input logic v);
    serial_in = v;
    repeat (16) @(negedge clk);
  endtask

  // Sends one frame and updates the reference model as the requirements state.
  task automatic xmit(input int nb, input logic [7:0] d, input bit has_par,
                      input logic pbit, input int nstop, input logic stopv,
                      input int idle, input bit expect_rx);
    logic [7:0] kept;
    bit pe, fe, bk, chk, odd, two;
    int ones;
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (has_par) hold_bit(pbit);
    for (int i = 0; i < nstop; i++) hold_bit(stopv);
    serial_in = 1'b1;
    repeat (idle) @(negedge clk);
    if (!expect_rx) return;
    kept = d & ((8'h01 << nb) - 8'h01);
    ones = $countones(kept) + (has_par ? int'(pbit) : 0);
    chk  = (cfg_par == 3'b000) || (cfg_par == 3'b001) || (cfg_par == 3'b010) || (cfg_par == 3'b011);
    odd  = (cfg_par == 3'b001) || (cfg_par == 3'b010);
    pe   = chk && ((ones % 2) != int'(odd));
    two  = cfg_stop2 && (nb != 5);
    fe   = (stopv == 1'b0);
    bk   = (ones == 0) && (stopv == 1'b0);
    if (two) fe = fe || (stopv == 1'b0);
    if (m_rdy) m_oe = 1;
    else begin
      m_data = kept; m_rdy = 1;
      m_pe = m_pe | pe; m_fe = m_fe | fe; m_bk = m_bk | bk;
    end
  endtask

  task automatic read_buf();
    rd_buf = 1'b1; @(negedge clk); rd_buf = 1'b0; @(negedge clk);
    m_rdy = 0;
  endtask

  task automatic read_stat();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
    m_pe = 0; m_fe = 0; m_oe = 0; m_bk = 0;
  endtask

  task automatic par_case(input logic [2:0] code, input logic [7:0] d, input logic pbit);
    cfg_par = code;
    xmit(8, d, 1, pbit, 1, 1'b1, 24, 1);
    cmp("R4", $sformatf("parity code %0b", code), int'(err_par), int'(m_pe));
    cmp_all("R4");
    read_buf(); read_stat();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_all("R1");

    // 8N1, LSB first
    xmit(8, 8'hA5, 0, 1'b0, 1, 1'b1, 24, 1);
    cmp_all("R2");
    read_buf();
    cmp_all("R10");

    // shorter words, upper bits of the source set to prove zero fill
    cfg_wlen = 2'b00; xmit(5, 8'hF3, 0, 1'b0, 1, 1'b1, 24, 1); cmp_all("R3"); read_buf();
    cfg_wlen = 2'b01; xmit(6, 8'hEA, 0, 1'b0, 1, 1'b1, 24, 1); cmp_all("R3"); read_buf();
    cfg_wlen = 2'b10; xmit(7, 8'hD5, 0, 1'b0, 1, 1'b1, 24, 1); cmp_all("R3"); read_buf();
    cfg_wlen = 2'b11;

    // parity modes
    par_case(3'b000, 8'h07, 1'b1);
    par_case(3'b000, 8'h07, 1'b0);
    par_case(3'b001, 8'h07, 1'b0);
    par_case(3'b001, 8'h07, 1'b1);
    par_case(3'b010, 8'h03, 1'b1);
    par_case(3'b011, 8'h03, 1'b1);
    par_case(3'b011, 8'h01, 1'b0);
    par_case(3'b100, 8'h07, 1'b0);
    par_case(3'b101, 8'h07, 1'b1);
    cfg_par = 3'b110;

    // framing error, sticky until status read
    xmit(8, 8'h5C, 0, 1'b0, 1, 1'b0, 24, 1);
    cmp_all("R6");
    read_buf();
    cmp("R11", "err_frm sticky", int'(err_frm), 1);
    read_stat();
    cmp_all("R11");

    // break
    xmit(8, 8'h00, 0, 1'b0, 1, 1'b0, 24, 1);
    cmp("R7", "brk_det", int'(brk_det), 1);
    cmp_all("R7");
    read_buf(); read_stat();
    cmp_all("R7");

    // two stop bits, second low
    cfg_stop2 = 1'b1;
    xmit(8, 8'h3C, 0, 1'b0, 1, 1'b1, 0, 0);
    hold_bit(1'b0);
    serial_in = 1'b1; repeat (24) @(negedge clk);
    m_data = 8'h3C; m_rdy = 1; m_fe = 1;
    cmp_all("R6");
    read_buf(); read_stat();

    // stop count timing: 5-bit completes at the first stop, 8-bit waits
    cfg_wlen = 2'b00;
    xmit(5, 8'h0A, 0, 1'b0, 1, 1'b1, 1, 1);
    cmp("R5", "5-bit done after one stop", int'(data_rdy), 1);
    repeat (30) @(negedge clk);
    cmp_all("R5");
    read_buf();
    cfg_wlen = 2'b11;
    xmit(8, 8'h81, 0, 1'b0, 1, 1'b1, 1, 1);
    cmp("R5", "8-bit pending second stop", int'(data_rdy), 0);
    repeat (30) @(negedge clk);
    cmp_all("R5");
    read_buf();
    cfg_stop2 = 1'b0;

    // short glitch is not a start bit
    serial_in = 1'b0; repeat (4) @(negedge clk);
    serial_in = 1'b1; repeat (40) @(negedge clk);
    cmp_all("R8");

    // overrun
    xmit(8, 8'h11, 0, 1'b0, 1, 1'b1, 24, 1);
    xmit(8, 8'h22, 0, 1'b0, 1, 1'b1, 24, 1);
    cmp("R9", "err_ovr", int'(err_ovr), 1);
    cmp_all("R9");
    read_buf(); read_stat();
    cmp_all("R9");

    // receiver disabled
    rx_en = 1'b0;
    xmit(8, 8'h5A, 0, 1'b0, 1, 1'b1, 24, 0);
    cmp_all("R12");
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    xmit(8, 8'h69, 0, 1'b0, 1, 1'b1, 24, 1);
    cmp_all("R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule